// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the two configuration dwords of a PCI function's power management capability. The first dword is read-only. It reports the capability identifier, the list link, the specification version, which low-power states are supported and which states can signal a wake. It also reports whether the function can wake from the unpowered D3 state and how much auxiliary current that needs. The second dword carries the current device power state, a PME enable bit, a sticky PME status bit and a small data-select field.

The D3cold wake bit is latched during any reset. It is set only when the auxiliary-power sense input is high and the configuration bit loaded from nonvolatile storage is set. That latched bit decides how far a hardware reset reaches. When D3cold wake is supported, PME enable and PME status survive a hardware reset, and only power-on reset clears them. When it is not supported, both resets clear them.

A wake event from outside sets the status bit. The block pulls its open-drain PME line low while status and enable are both set. Configuration software uses a dword read/write port with byte enables and sees read data one cycle after the read strobe.

Top module: `pm_cap_regs`

## Requirements
- R1: Following a power-on reset, the control word reads 0: power state D0, enable 0, status 0 and data select 0. `pme_oe` is 0.
- R2: A write to the control word (`cfg_sel`=1) with `cfg_be[0]`=1 loads bits 1:0 as the power state (0=D0, 1=D1, 2=D2, 3=D3hot), provided the value is a supported state.
- R3: A written power state of D1 when `SUPPORT_D1`=0, or D2 when `SUPPORT_D2`=0, is discarded and the previous state is kept.
- R4: `wake_evt` sets status bit 15 whatever the value of the enable bit. A wake event in the same cycle as a clearing write leaves the bit set.
- R5: A control write with `cfg_be[1]`=1 and bit 15 = 1 clears the status bit. Bit 15 = 0 leaves it unchanged.
- R6: `pme_oe` (1 = pull PME# low, 0 = release) is 1 in the cycle after status and enable are both 1, and 0 otherwise.
- R7: Any reset latches D3cold wake support as `aux_det` AND `nv_d3c_en`. The capability word shows it in bit 31, and bits 24:22 read 111 when it is set and 000 when it is clear.
- R8: Power-on reset always clears enable and status. A hardware reset clears them only when the support value it latches is 0; otherwise they keep their values. Both resets return the state to D0 and data select to 0.
- R9: The capability word (`cfg_sel`=0) reads: bits 7:0 = 01h, bits 15:8 = 00h, bits 18:16 = 010b, bits 21:19 = 0, bit 25 = `SUPPORT_D1`, bit 26 = `SUPPORT_D2`, bits 27 and 30 = 1, bit 28 = `SUPPORT_D1`, bit 29 = `SUPPORT_D2`. Writes to it have no effect.
- R10: Bits 12:9 (data select) and bit 8 (enable) are written when `cfg_be[1]`=1. Bits 14:13 always read 0. `cfg_be[2]` and `cfg_be[3]` affect nothing, and a byte whose enable is 0 is left unchanged.
- R11: `cfg_rdata` is loaded in the cycle after `cfg_rd` with the selected word's value from before any write in the same cycle. It holds when no read occurs and is 0 after any reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| aux_det | input | 1 | Auxiliary power present, sampled during reset |
| nv_d3c_en | input | 1 | D3cold wake enable bit loaded from nonvolatile storage |
| wake_evt | input | 1 | Wake event pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 1 | 0 = capability word, 1 = control/status word |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| pme_oe | output | 1 | Pull-down enable for the open-drain PME# line |

## Verification
The bench builds two instances side by side. The first uses the default parameters, with both low-power states supported. The second sets `SUPPORT_D2`=0, so the same D2 write is accepted by one instance and discarded by the other, and the capability support bits differ between the two. Both instances get the same stimulus. Resets are applied with the strap inputs in each combination, which covers the retention and non-retention paths of a hardware reset.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CFG_DW = 32;
  localparam int CFG_BE_W = CFG_DW / 8;
  localparam int PS_W = 2;
  localparam int DSEL_W = 4;
  localparam int NUM_PS = 1 << PS_W;

  typedef enum logic [PS_W-1:0] {
    PS_D0    = 2'd0,
    PS_D1    = 2'd1,
    PS_D2    = 2'd2,
    PS_D3HOT = 2'd3
  } pstate_e;

  localparam logic [7:0] CAP_ID     = 8'h01;
  localparam logic [7:0] CAP_NEXT   = 8'h00;
  localparam logic [2:0] CAP_VER    = 3'b010;
  localparam logic [2:0] AUX_I_FULL = 3'b111;

  localparam int BIT_EN = 8;
  localparam int BIT_DSEL_LO = 9;
  localparam int BIT_ST = 15;
endpackage

// File: rtl/pm_strap.sv
module pm_strap (
  input  logic clk,
  input  logic por_rst,
  input  logic hw_rst,
  input  logic aux_det,
  input  logic nv_d3c_en,
  output logic d3c_live,
  output logic d3c_sup
);
  assign d3c_live = aux_det & nv_d3c_en;

  always_ff @(posedge clk) begin
    if (por_rst || hw_rst) d3c_sup <= d3c_live;
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter bit SUPPORT_D1 = 1'b1,
  parameter bit SUPPORT_D2 = 1'b1
) (
  input  logic                clk,
  input  logic                por_rst,
  input  logic                hw_rst,
  input  logic                d3c_live,
  input  logic                wr_ctl,
  input  logic [CFG_BE_W-1:0] be,
  input  logic [CFG_DW-1:0]   wdata,
  input  logic                wake,
  output pstate_e             pstate,
  output logic                pme_en,
  output logic                pme_st,
  output logic [DSEL_W-1:0]   dsel,
  output logic                pme_oe
);
  logic [NUM_PS-1:0] st_ok;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PS; gi++) begin : g_ok
      if (gi == int'(PS_D1)) begin : g_d1
        assign st_ok[gi] = SUPPORT_D1;
      end else if (gi == int'(PS_D2)) begin : g_d2
        assign st_ok[gi] = SUPPORT_D2;
      end else begin : g_base
        assign st_ok[gi] = 1'b1;
      end
    end
  endgenerate

  pstate_e           pstate_n;
  logic              en_n, st_n;
  logic [DSEL_W-1:0] dsel_n;
  logic [PS_W-1:0]   req;
  logic              any_rst, keep_sticky;

  assign req = wdata[PS_W-1:0];
  assign any_rst = por_rst | hw_rst;
  assign keep_sticky = hw_rst & ~por_rst & d3c_live;

  always_comb begin
    pstate_n = pstate;
    en_n = pme_en;
    st_n = pme_st;
    dsel_n = dsel;
    if (any_rst) begin
      pstate_n = PS_D0;
      dsel_n = '0;
      if (!keep_sticky) begin
        en_n = 1'b0;
        st_n = 1'b0;
      end
    end else begin
      if (wr_ctl && be[0] && st_ok[req]) pstate_n = pstate_e'(req);
      if (wr_ctl && be[1]) begin
        en_n = wdata[BIT_EN];
        dsel_n = wdata[BIT_DSEL_LO +: DSEL_W];
        if (wdata[BIT_ST]) st_n = 1'b0;
      end
      if (wake) st_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    pstate <= pstate_n;
    pme_en <= en_n;
    pme_st <= st_n;
    dsel <= dsel_n;
    pme_oe <= st_n & en_n;
  end
endmodule

// File: rtl/pm_rdport.sv
module pm_rdport
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              sel,
  input  logic [CFG_DW-1:0] cap_word,
  input  logic [CFG_DW-1:0] ctl_word,
  output logic [CFG_DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= sel ? ctl_word : cap_word;
  end
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_pkg::*;
#(
  parameter bit SUPPORT_D1 = 1'b1,
  parameter bit SUPPORT_D2 = 1'b1
) (
  input  logic                clk,
  input  logic                por_rst,
  input  logic                hw_rst,
  input  logic                aux_det,
  input  logic                nv_d3c_en,
  input  logic                wake_evt,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic                cfg_sel,
  input  logic [CFG_BE_W-1:0] cfg_be,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic [CFG_DW-1:0]   cfg_rdata,
  output logic                pme_oe
);
  logic              d3c_live, d3c_sup_q;
  pstate_e           pstate_q;
  logic              pme_en_q, pme_st_q;
  logic [DSEL_W-1:0] dsel_q;
  logic [CFG_DW-1:0] cap_word, ctl_word;

  pm_strap u_strap (
    .clk      (clk),
    .por_rst  (por_rst),
    .hw_rst   (hw_rst),
    .aux_det  (aux_det),
    .nv_d3c_en(nv_d3c_en),
    .d3c_live (d3c_live),
    .d3c_sup  (d3c_sup_q)
  );

  pm_ctrl #(
    .SUPPORT_D1(SUPPORT_D1),
    .SUPPORT_D2(SUPPORT_D2)
  ) u_ctrl (
    .clk     (clk),
    .por_rst (por_rst),
    .hw_rst  (hw_rst),
    .d3c_live(d3c_live),
    .wr_ctl  (cfg_wr & cfg_sel),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .wake    (wake_evt),
    .pstate  (pstate_q),
    .pme_en  (pme_en_q),
    .pme_st  (pme_st_q),
    .dsel    (dsel_q),
    .pme_oe  (pme_oe)
  );

  // Wake-capable states: D3cold, D3hot, D2, D1, D0 (bits 31..27)
  assign cap_word = {d3c_sup_q, 1'b1, SUPPORT_D2, SUPPORT_D1, 1'b1,
                     SUPPORT_D2, SUPPORT_D1,
                     d3c_sup_q ? AUX_I_FULL : 3'b000,
                     3'b000, CAP_VER, CAP_NEXT, CAP_ID};

  assign ctl_word = {16'h0000, pme_st_q, 2'b00, dsel_q, pme_en_q,
                     6'b000000, pstate_q};

  pm_rdport u_rd (
    .clk     (clk),
    .rst     (por_rst | hw_rst),
    .rd      (cfg_rd),
    .sel     (cfg_sel),
    .cap_word(cap_word),
    .ctl_word(ctl_word),
    .rdata   (cfg_rdata)
  );
endmodule

// File: rtl/pm_cap_chk.sv
module pm_cap_chk #(
  parameter bit SUPPORT_D1 = 1'b1,
  parameter bit SUPPORT_D2 = 1'b1
) (
  input logic        clk,
  input logic        por_rst,
  input logic        hw_rst,
  input logic        aux_det,
  input logic        nv_d3c_en,
  input logic        wake_evt,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic        cfg_sel,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        pme_oe,
  input logic [1:0]  pstate,
  input logic        pme_en,
  input logic        pme_st,
  input logic        d3c_sup
);
  logic unsup_wr;
  assign unsup_wr = cfg_wr && cfg_sel && cfg_be[0] &&
                    ((cfg_wdata[1:0] == 2'b01 && !SUPPORT_D1) ||
                     (cfg_wdata[1:0] == 2'b10 && !SUPPORT_D2));

  p_unsup_hold_r3: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    unsup_wr |=> $stable(pstate));

  p_wake_sets_r4: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    wake_evt |=> pme_st);

  p_zero_keeps_r5: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    (cfg_wr && cfg_sel && cfg_be[1] && !cfg_wdata[15] && pme_st) |=> pme_st);

  p_oe_match_r6: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    (pme_st && pme_en) |-> pme_oe);

  p_strap_stable_r7: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    $past(!por_rst && !hw_rst) |-> $stable(d3c_sup));

  p_retain_r8: assert property (@(posedge clk) disable iff (por_rst)
    (hw_rst && aux_det && nv_d3c_en && pme_st) |=> pme_st);

  p_cap_id_r9: assert property (@(posedge clk) disable iff (por_rst || hw_rst)
    (cfg_rd && !cfg_sel) |=> (cfg_rdata[7:0] == 8'h01 && cfg_rdata[18:16] == 3'b010));
endmodule

bind pm_cap_regs pm_cap_chk #(
  .SUPPORT_D1(SUPPORT_D1),
  .SUPPORT_D2(SUPPORT_D2)
) u_chk (
  .clk      (clk),
  .por_rst  (por_rst),
  .hw_rst   (hw_rst),
  .aux_det  (aux_det),
  .nv_d3c_en(nv_d3c_en),
  .wake_evt (wake_evt),
  .cfg_wr   (cfg_wr),
  .cfg_rd   (cfg_rd),
  .cfg_sel  (cfg_sel),
  .cfg_be   (cfg_be),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .pme_oe   (pme_oe),
  .pstate   (pstate_q),
  .pme_en   (pme_en_q),
  .pme_st   (pme_st_q),
  .d3c_sup  (d3c_sup_q)
);

// File: tb/pm_cap_regs_bench.sv
`timescale 1ns/1ps
module pm_cap_regs_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por = 1'b0, hw = 1'b0, aux = 1'b0, nv = 1'b0, wake = 1'b0;
  logic wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [3:0] be = 4'h0;
  logic [31:0] wd = '0;
  logic [31:0] rdata [2];
  logic oe [2];
  int total = 0, bad = 0;
  bit done = 0;

  pm_cap_regs u_pm_cap_regs (
    .clk(clk), .por_rst(por), .hw_rst(hw), .aux_det(aux), .nv_d3c_en(nv),
    .wake_evt(wake), .cfg_wr(wr), .cfg_rd(rd), .cfg_sel(sel), .cfg_be(be),
    .cfg_wdata(wd), .cfg_rdata(rdata[0]), .pme_oe(oe[0]));

  pm_cap_regs #(.SUPPORT_D1(1'b1), .SUPPORT_D2(1'b0)) u_pm_cap_regs_nod2 (
    .clk(clk), .por_rst(por), .hw_rst(hw), .aux_det(aux), .nv_d3c_en(nv),
    .wake_evt(wake), .cfg_wr(wr), .cfg_rd(rd), .cfg_sel(sel), .cfg_be(be),
    .cfg_wdata(wd), .cfg_rdata(rdata[1]), .pme_oe(oe[1]));

  // behavioural reference state per instance
  int m_ps [2], m_ds [2];
  bit m_en [2], m_st [2], m_d3c [2], m_oe [2];
  logic [31:0] m_rd [2];

  function automatic logic [31:0] cap_exp(int i);
    bit d2 = (i == 0);
    return {m_d3c[i], 1'b1, d2, 1'b1, 1'b1, d2, 1'b1, {3{m_d3c[i]}},
            3'b000, 3'b010, 8'h00, 8'h01};
  endfunction

  function automatic logic [31:0] ctl_exp(int i);
    return {16'h0, m_st[i], 2'b00, 4'(m_ds[i]), m_en[i], 6'b0, 2'(m_ps[i])};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      if (rd) m_rd[i] = sel ? ctl_exp(i) : cap_exp(i);
      if (por || hw) begin
        bit live = aux & nv;
        m_d3c[i] = live;
        m_ps[i] = 0;
        m_ds[i] = 0;
        m_rd[i] = '0;
        if (por || !live) begin m_en[i] = 0; m_st[i] = 0; end
      end else begin
        if (wr && sel && be[0] && !(wd[1:0] == 2'b10 && i == 1)) m_ps[i] = int'(wd[1:0]);
        if (wr && sel && be[1]) begin
          m_en[i] = wd[8];
          m_ds[i] = int'(wd[12:9]);
          if (wd[15]) m_st[i] = 0;
        end
        if (wake) m_st[i] = 1;
      end
      m_oe[i] = m_st[i] & m_en[i];
    end
  endtask

  // one clock: model follows the edge, outputs compared after it
  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R11 inst%0d rdata per-cycle", i), rdata[i], m_rd[i]);
      chk($sformatf("R6 inst%0d pme_oe per-cycle", i), 32'(oe[i]), 32'(m_oe[i]));
    end
  endtask

  task automatic wr_word(logic s, logic [3:0] b, logic [31:0] d);
    wr = 1; sel = s; be = b; wd = d;
    tick();
    wr = 0; be = 0; wd = 0;
  endtask

  task automatic rd_word(logic s);
    rd = 1; sel = s;
    tick();
    rd = 0;
  endtask

  task automatic do_reset(bit p, bit a, bit n);
    por = p; hw = !p; aux = a; nv = n;
    tick(); tick();
    por = 0; hw = 0;
  endtask

  task automatic pulse_wake();
    wake = 1; tick(); wake = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1, 1, 1);
    rd_word(0);
    chk("R7 R9 cap d3c on inst0", rdata[0], 32'hFFC20001);
    chk("R9 cap no-D2 inst1", rdata[1], 32'hDBC20001);
    rd_word(1);
    chk("R1 ctrl after por", rdata[0], 32'h0);
    chk("R1 pme_oe after por", 32'(oe[0]), 32'h0);

    wr_word(1, 4'h1, 32'h3); rd_word(1);
    chk("R2 state D3hot", rdata[0], 32'h3);
    wr_word(1, 4'h1, 32'h2); rd_word(1);
    chk("R2 state D2 accepted", rdata[0], 32'h2);
    chk("R3 D2 discarded when unsupported", rdata[1], 32'h3);

    wr_word(1, 4'h2, 32'h0000F501); rd_word(1);
    chk("R10 enable+dsel, scale zero, byte0 kept", rdata[0], 32'h1502);

    pulse_wake();
    chk("R6 pme_oe on", 32'(oe[0]), 32'h1);
    rd_word(1);
    chk("R4 status set", rdata[0], 32'h9502);

    wr_word(1, 4'h2, 32'h1500); rd_word(1);
    chk("R5 zero leaves status", rdata[0], 32'h9502);
    wr_word(1, 4'h1, 32'h8002); rd_word(1);
    chk("R10 bit15 needs byte1 enable", rdata[0], 32'h9502);
    wr_word(1, 4'hC, 32'hFFFFFFFF); rd_word(1);
    chk("R10 upper bytes ignored", rdata[0], 32'h9502);
    wr_word(1, 4'h2, 32'h9500); rd_word(1);
    chk("R5 one clears status", rdata[0], 32'h1502);
    chk("R6 pme_oe off after clear", 32'(oe[0]), 32'h0);

    wr_word(1, 4'h2, 32'h1400);
    pulse_wake();
    chk("R6 no pull without enable", 32'(oe[0]), 32'h0);
    rd_word(1);
    chk("R4 status set with enable 0", rdata[0], 32'h9402);

    wake = 1; wr_word(1, 4'h2, 32'h9400); wake = 0; rd_word(1);
    chk("R4 wake wins over clear", rdata[0], 32'h9402);

    wr_word(1, 4'h2, 32'h9500);
    pulse_wake();
    do_reset(0, 1, 1);
    rd_word(1);
    chk("R8 hw reset retains with d3c", rdata[0], 32'h8100);
    chk("R8 pme_oe retained", 32'(oe[0]), 32'h1);

    do_reset(0, 0, 1);
    rd_word(1);
    chk("R8 hw reset clears without d3c", rdata[0], 32'h0);
    rd_word(0);
    chk("R7 cap no d3c inst0", rdata[0], 32'h7E020001);
    chk("R7 cap no d3c inst1", rdata[1], 32'h5A020001);

    do_reset(1, 1, 0);
    rd_word(0);
    chk("R7 nv bit clear gives no d3c", rdata[0], 32'h7E020001);

    do_reset(1, 1, 1);
    wr_word(1, 4'h2, 32'h0100);
    pulse_wake();
    do_reset(1, 1, 1);
    rd_word(1);
    chk("R8 por clears even with d3c", rdata[0], 32'h0);

    wr_word(0, 4'hF, 32'hFFFFFFFF); rd_word(0);
    chk("R9 cap write ignored", rdata[0], 32'hFFC20001);

    rd_word(1);
    wr_word(1, 4'h1, 32'h3);
    tick();
    chk("R11 rdata holds without read", rdata[0], 32'h0);
    rd = 1; wr_word(1, 4'h1, 32'h1); rd = 0;
    chk("R11 read sees pre-write value", rdata[0], 32'h3);
    rd_word(1);
    chk("R2 state D1", rdata[0], 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule